// File: doc/BRIEF.md
# Descriptor Done-Queue Write Coalescer

The coalescer is placed between a transmit DMA engine and the done queue kept in host memory. Each completed-descriptor entry that the engine hands over goes into a 16-entry internal FIFO. From there it is written to memory through a simple request/acknowledge port. A control bit picks one of two write modes. With the bit clear, each entry goes out as its own write. With the bit set, entries are gathered and sent as bursts of up to eight beats. A flush bit forces out whatever is held, even when fewer than eight entries are waiting.

A counter tracks how many entries the memory port has actually accepted. It saturates at 128. A sticky status flag rises once that count reaches 2^N, where N is a 3-bit code in the control register. Writing 1 to the status register clears both the flag and the counter. When the FIFO is full the input stream is back-pressured, so no entry is ever lost.

Top module: `dqc_top`

## Requirements
- R1: After reset, burst mode, flush and the threshold code are all 0, `sts_flag` is 0, `mw_req` is 0 and `desc_ready` is 1. A descriptor sent straight after reset is therefore written as a single write.
- R2: The FIFO holds 16 entries. With 16 held, `desc_ready` is 0 and a descriptor offered on `desc_valid` is not taken. Every accepted entry reaches `mw_data` exactly once, in arrival order.
- R3: Control register layout for `ctl_wdata`: bit 0 is burst enable, bit 1 is flush and bits 4:2 are the threshold code. With burst enable 0, each entry is written as its own request with `mw_burst`=0 and `mw_last`=1. `mw_req` is high in the cycle right after the clock edge that accepted the entry into an empty FIFO.
- R4: With burst enable 1 and flush 0, no request is made while fewer than 8 entries are held. When the 8th entry is accepted at an edge, `mw_req` stays low for one cycle and rises after the next edge.
- R5: A burst has `mw_burst`=1 on every beat and at most 8 beats. `mw_last` marks its final beat: either the 8th beat, or the beat that takes the last held entry.
- R6: With burst enable 1 and flush 1, bursts are started even when fewer than 8 entries are held, and they repeat until the FIFO is empty. This includes entries left over when flush is raised partway through a burst.
- R7: An entry counts as written only on a cycle where `mw_req` and `mw_ack` are both 1. While `mw_ack` is 0 the request stays up and `mw_data` does not change.
- R8: For threshold code N (0 to 7), `sts_flag` is set by the edge at which the written count reaches 2^N. It then stays set until cleared.
- R9: A status write (`sts_we`=1 with `sts_wdata`=1) clears `sts_flag` and the written count at that edge. Counting then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control value: bit0 burst enable, bit1 flush, bits4:2 threshold code |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 1 | Status write value; 1 clears flag and count |
| sts_flag | output | 1 | Sticky done-queue written flag |
| desc_valid | input | 1 | Completed-descriptor entry offered |
| desc_ready | output | 1 | Entry can be accepted |
| desc_data | input | 32 | Completed-descriptor entry |
| mw_req | output | 1 | Memory write request |
| mw_burst | output | 1 | Current beat belongs to a burst |
| mw_last | output | 1 | Current beat ends its write |
| mw_data | output | 32 | Entry to write to the done queue |
| mw_ack | input | 1 | Memory port accepts the current beat |

## Verification
In single mode a request is due in the cycle right after the edge that stored the entry. In burst mode it is due one edge later than the condition that starts the burst, whether that is the 8th held entry or a flush write. The flag and a clear both take effect at the edge of the acknowledged beat or of the status write. The bench changes inputs just after a rising edge and samples right after the edge where each result is due, so its checks land in exactly those cycles. A monitor on the falling edge records every accepted beat: it checks the data against an arrival-order model and collects the burst lengths, which the scenarios then compare with the lengths expected for their entry counts.

// File: rtl/dqc_pkg.sv
`timescale 1ns/1ps
package dqc_pkg;
    localparam int DATA_W     = 32;
    localparam int FIFO_DEPTH = 16;
    localparam int BURST_MAX  = 8;
    localparam int THR_W      = 3;
    localparam int CTL_W      = 2 + THR_W;
    localparam int CNT_SAT    = 1 << ((1 << THR_W) - 1);

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             flush;
        logic             burst_en;
    } ctl_t;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_e;

    function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.burst_en = w[0];
        c.flush    = w[1];
        c.thr      = w[CTL_W-1:2];
        return c;
    endfunction
endpackage

// File: rtl/dqc_fifo.sv
`timescale 1ns/1ps
module dqc_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign rdata = mem[rd_ptr];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/dqc_seq.sv
`timescale 1ns/1ps
module dqc_seq
    import dqc_pkg::*;
#(
    parameter int CW        = 5,
    parameter int BURST_MAX = 8,
    parameter int BW        = $clog2(BURST_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          burst_en,
    input  logic          flush,
    input  logic [CW-1:0] count,
    input  logic          ack,
    output logic          req,
    output logic          burst,
    output logic          last
);
    seq_state_e    state_q, state_d;
    logic [BW-1:0] beat_q;
    logic          start;

    always_comb begin
        start   = burst_en && ((count >= CW'(BURST_MAX)) || (flush && (count != '0)));
        state_d = state_q;
        req     = 1'b0;
        burst   = 1'b0;
        last    = 1'b1;
        case (state_q)
            SEQ_IDLE: begin
                req = !burst_en && (count != '0);
                if (start) state_d = SEQ_BURST;
            end
            SEQ_BURST: begin
                req   = 1'b1;
                burst = 1'b1;
                last  = (beat_q == BW'(BURST_MAX - 1)) || (count == CW'(1));
                if (ack && last) state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != SEQ_BURST)
                beat_q <= '0;
            else if (ack)
                beat_q <= beat_q + BW'(1);
        end
    end
endmodule

// File: rtl/dqc_status.sv
`timescale 1ns/1ps
module dqc_status
    import dqc_pkg::*;
#(
    parameter int SAT   = 128,
    parameter int CNT_W = $clog2(SAT + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             written,
    input  logic             clear,
    input  logic [THR_W-1:0] thr,
    output logic             flag
);
    logic [CNT_W-1:0] cnt_q, cnt_d, level;
    logic             flag_q;

    always_comb begin
        level = CNT_W'(1) << thr;
        if (clear)
            cnt_d = written ? CNT_W'(1) : '0;
        else if (written && (cnt_q != CNT_W'(SAT)))
            cnt_d = cnt_q + CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= (flag_q && !clear) || (cnt_d >= level);
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/dqc_top.sv
`timescale 1ns/1ps
module dqc_top
    import dqc_pkg::*;
#(
    parameter int DATA_W     = dqc_pkg::DATA_W,
    parameter int FIFO_DEPTH = dqc_pkg::FIFO_DEPTH,
    parameter int BURST_MAX  = dqc_pkg::BURST_MAX,
    parameter int CNT_SAT    = dqc_pkg::CNT_SAT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              sts_we,
    input  logic              sts_wdata,
    output logic              sts_flag,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [DATA_W-1:0] desc_data,
    output logic              mw_req,
    output logic              mw_burst,
    output logic              mw_last,
    output logic [DATA_W-1:0] mw_data,
    input  logic              mw_ack
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    ctl_t          ctl_q;
    logic [CW-1:0] fifo_cnt;
    logic          fifo_full, fifo_empty;
    logic          push, pop;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_decode(ctl_wdata);
    end

    assign desc_ready = !fifo_full;
    assign push       = desc_valid && !fifo_full;
    assign pop        = mw_req && mw_ack;

    dqc_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (desc_data),
        .pop   (pop),
        .rdata (mw_data),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    dqc_seq #(.CW(CW), .BURST_MAX(BURST_MAX)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .burst_en (ctl_q.burst_en),
        .flush    (ctl_q.flush && !fifo_empty),
        .count    (fifo_cnt),
        .ack      (mw_ack),
        .req      (mw_req),
        .burst    (mw_burst),
        .last     (mw_last)
    );

    dqc_status #(.SAT(CNT_SAT)) u_status (
        .clk     (clk),
        .rst     (rst),
        .written (pop),
        .clear   (sts_we && sts_wdata),
        .thr     (ctl_q.thr),
        .flag    (sts_flag)
    );
endmodule

// File: rtl/dqc_chk.sv
`timescale 1ns/1ps
module dqc_chk #(
    parameter int DW        = 32,
    parameter int DEPTH     = 16,
    parameter int BURST_MAX = 8,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          mw_req,
    input logic          mw_ack,
    input logic          mw_burst,
    input logic          mw_last,
    input logic [DW-1:0] mw_data,
    input logic          sts_flag,
    input logic          sts_we,
    input logic          sts_wdata,
    input logic          desc_ready,
    input logic [CW-1:0] fifo_cnt
);
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (mw_req && mw_ack && mw_burst)
            run_q <= mw_last ? '0 : run_q + 8'd1;
    end

    // R2: a full FIFO must stall the input
    assert_full_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CW'(DEPTH)) |-> !desc_ready);

    // R3: no request without a held entry
    assert_req_has_entry_R3: assert property (@(posedge clk) disable iff (rst)
        mw_req |-> (fifo_cnt != '0));

    // R5: a burst never exceeds its beat limit
    assert_burst_len_R5: assert property (@(posedge clk) disable iff (rst)
        (mw_req && mw_ack && mw_burst) |-> (run_q < 8'(BURST_MAX)));

    // R7: an unacknowledged burst beat holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (mw_req && mw_burst && !mw_ack) |=> (mw_req && $stable(mw_data)));

    // R8: flag is sticky
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (sts_flag && !(sts_we && sts_wdata)) |=> sts_flag);

    // R9: clear drops the flag when no write lands in the same cycle
    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (sts_we && sts_wdata && !(mw_req && mw_ack)) |=> !sts_flag);
endmodule

bind dqc_top dqc_chk #(.DW(DATA_W), .DEPTH(FIFO_DEPTH), .BURST_MAX(BURST_MAX)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mw_req     (mw_req),
    .mw_ack     (mw_ack),
    .mw_burst   (mw_burst),
    .mw_last    (mw_last),
    .mw_data    (mw_data),
    .sts_flag   (sts_flag),
    .sts_we     (sts_we),
    .sts_wdata  (sts_wdata),
    .desc_ready (desc_ready),
    .fifo_cnt   (fifo_cnt)
);

// File: tb/test_dqc_top.sv
`timescale 1ns/1ps
module test_dqc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [4:0]  ctl_wdata = '0;
    logic        sts_we = 1'b0;
    logic        sts_wdata = 1'b0;
    logic        sts_flag;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] desc_data = '0;
    logic        mw_req, mw_burst, mw_last;
    logic [31:0] mw_data;
    logic        mw_ack = 1'b0;

    always #5 clk = ~clk;

    dqc_top i_dqc_top (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_flag(sts_flag),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_data(desc_data),
        .mw_req(mw_req), .mw_burst(mw_burst), .mw_last(mw_last),
        .mw_data(mw_data), .mw_ack(mw_ack)
    );

    int          checks = 0;
    int          fails  = 0;
    int          beats  = 0;
    int          run    = 0;
    int          bursts[$];
    logic [31:0] exp_q[$];
    bit          done = 0;

    task automatic chk(input string tag, input longint act, input longint exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // beat monitor: ack and req are stable at the falling edge
    always @(negedge clk) begin
        if (!rst && mw_req && mw_ack) begin
            beats++;
            if (exp_q.size() == 0)
                chk("R2", 1, 0, "write with no pending entry");
            else
                chk("R2", mw_data, exp_q.pop_front(), "write order");
            if (mw_burst) begin
                run++;
                if (mw_last) begin
                    bursts.push_back(run);
                    run = 0;
                end
            end else begin
                chk("R3", mw_last, 1, "single write marked last");
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [31:0] d);
        desc_valid = 1'b1;
        desc_data  = d;
        while (!desc_ready) tick();
        tick();
        desc_valid = 1'b0;
        exp_q.push_back(d);
    endtask

    task automatic set_ctl(input logic be, input logic fl, input logic [2:0] thr);
        ctl_we    = 1'b1;
        ctl_wdata = {thr, fl, be};
        tick();
        ctl_we = 1'b0;
    endtask

    task automatic sts_clear();
        sts_we    = 1'b1;
        sts_wdata = 1'b1;
        tick();
        sts_we    = 1'b0;
        sts_wdata = 1'b0;
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) tick();
        tick();
        tick();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic t_reset_R1();
        chk("R1", desc_ready, 1, "ready after reset");
        chk("R1", mw_req, 0, "req after reset");
        chk("R1", sts_flag, 0, "flag after reset");
    endtask

    task automatic t_single_R3();
        int b0;
        mw_ack = 1'b0;
        push(32'd100);
        chk("R1", mw_req, 1, "single write by default after reset");
        chk("R3", mw_burst, 0, "single write not a burst");
        chk("R3", mw_last, 1, "single write last");
        repeat (3) tick();
        chk("R7", mw_req, 1, "request held without ack");
        chk("R7", mw_data, 100, "data held without ack");
        chk("R7", sts_flag, 0, "no count without ack");
        mw_ack = 1'b1;
        tick();
        chk("R8", sts_flag, 1, "code 0 flag after one write");
        chk("R3", mw_req, 0, "fifo empty after write");
        b0 = beats;
        push(32'd101);
        push(32'd102);
        push(32'd103);
        wait_drain();
        chk("R3", beats - b0, 3, "three single writes");
        chk("R3", bursts.size(), 0, "no bursts in single mode");
    endtask

    task automatic t_clear_R9();
        sts_clear();
        chk("R9", sts_flag, 0, "flag cleared by status write");
    endtask

    task automatic t_backpressure_R2();
        int b0;
        b0 = beats;
        mw_ack = 1'b0;
        for (int i = 0; i < 16; i++) push(32'd200 + 32'(i));
        chk("R2", desc_ready, 0, "ready low with 16 held");
        desc_valid = 1'b1;
        desc_data  = 32'd999;
        repeat (3) tick();
        chk("R2", desc_ready, 0, "ready stays low while full");
        desc_valid = 1'b0;
        mw_ack = 1'b1;
        push(32'd216);
        wait_drain();
        chk("R2", beats - b0, 17, "all held entries written once");
        chk("R2", exp_q.size(), 0, "nothing left pending");
    endtask

    task automatic t_burst_R4_R5_R6();
        int b0;
        set_ctl(1'b1, 1'b0, 3'd0);
        mw_ack = 1'b1;
        b0 = beats;
        for (int i = 0; i < 7; i++) push(32'd300 + 32'(i));
        repeat (4) tick();
        chk("R4", beats - b0, 0, "no write below 8 held");
        chk("R4", mw_req, 0, "no request below 8 held");
        push(32'd307);
        chk("R4", mw_req, 0, "request not yet up after 8th entry");
        tick();
        chk("R4", mw_req, 1, "request up one edge later");
        chk("R5", mw_burst, 1, "burst flag on beat");
        wait_drain();
        chk("R5", bursts.size(), 1, "one burst");
        chk("R5", bursts[0], 8, "burst of 8");
        for (int i = 0; i < 12; i++) push(32'd320 + 32'(i));
        repeat (12) tick();
        chk("R5", bursts.size(), 2, "second burst");
        chk("R5", bursts[1], 8, "second burst length");
        chk("R4", exp_q.size(), 4, "remainder held without flush");
        chk("R4", mw_req, 0, "no request for remainder");
        set_ctl(1'b1, 1'b1, 3'd0);
        tick();
        wait_drain();
        chk("R6", bursts.size(), 3, "flush burst");
        chk("R6", bursts[2], 4, "flush burst ends on last entry");
        chk("R6", exp_q.size(), 0, "flush empties fifo");
        set_ctl(1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_flush_midburst_R6();
        int n0;
        mw_ack = 1'b0;
        n0 = bursts.size();
        for (int i = 0; i < 11; i++) push(32'd400 + 32'(i));
        tick();
        tick();
        chk("R6", mw_req, 1, "burst pending before flush");
        mw_ack = 1'b1;
        repeat (3) tick();
        mw_ack = 1'b0;
        tick();
        set_ctl(1'b1, 1'b1, 3'd0);
        mw_ack = 1'b1;
        tick();
        wait_drain();
        chk("R6", bursts.size() - n0, 2, "interrupted burst plus flush burst");
        chk("R6", bursts[n0], 8, "first burst completes 8 beats");
        chk("R6", bursts[n0+1], 3, "leftover flushed");
        chk("R6", exp_q.size(), 0, "fifo drained by flush");
        set_ctl(1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_thresholds_R8();
        mw_ack = 1'b1;
        for (int n = 0; n < 8; n++) begin
            int lvl;
            lvl = 1 << n;
            set_ctl(1'b0, 1'b0, 3'(n));
            sts_clear();
            chk("R9", sts_flag, 0, "flag clear before threshold run");
            for (int i = 0; i < lvl - 1; i++) push(32'd1000 + 32'(i));
            wait_drain();
            chk("R8", sts_flag, 0, $sformatf("code %0d below threshold", n));
            push(32'd2000 + 32'(n));
            wait_drain();
            chk("R8", sts_flag, 1, $sformatf("code %0d at threshold", n));
        end
        for (int i = 0; i < 5; i++) push(32'd3000 + 32'(i));
        wait_drain();
        chk("R8", sts_flag, 1, "flag stays set past threshold");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset_R1();
        t_single_R3();
        t_clear_R9();
        t_backpressure_R2();
        t_burst_R4_R5_R6();
        t_flush_midburst_R6();
        t_thresholds_R8();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end
endmodule